// File: doc/BRIEF.md
# Command-Stepped I2C Target

This block is an I2C target whose bus behaviour is driven entirely by software, one bus step at a time. Software writes a 3-bit step code and a go bit into a control register. The block then performs exactly that step on the open-drain SCL/SDA pair. The available steps are: wait for a start condition, shift out a byte, shift in a byte (or notice a stop condition), drive ACK, drive NAK, and sample the acknowledge bit from the controller. The block never answers the bus on its own. Even the acknowledge after an address byte must be requested explicitly, after software has compared the received byte against its own address.

When a step finishes, the block sets a done flag and drives the interrupt output. It also records a 3-bit result code telling which kind of step ended and how. The go bit reads back as 1 while a step is pending or in progress, and as 0 once it is over. The controller owns SCL. The target only samples it and never holds the clock low. A slave-mode enable input gates the launch logic.

Top module: `i2c_step_target`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the status register (address 2) reads 0x00, `irq` is 0 and `sda_drive` is 0.
- R2: Control register layout: bits [2:0] hold the step code and bit 4 is the go/busy bit. Bits 7:5 and 3 always read 0. Writing bit 4 as 1 launches the step, and writing it as 0 launches nothing. While a step is busy, control writes are ignored.
- R3: While `slave_en` is 0, writing the go bit launches nothing: busy stays 0 and no done flag is set.
- R4: Step code 1 waits for a start condition (SDA falling while SCL is high) and then completes with result code 0.
- R5: Step code 3 sends the byte last written to address 1, MSB first. Each bit is put on SDA while SCL is low and advances after each SCL falling edge. SDA is released after the eighth falling edge, and the step completes with result code 2.
- R6: Step code 4 samples SDA on eight SCL rising edges, MSB first. It then completes with result code 3, and the byte reads from address 1.
- R7: A stop condition (SDA rising while SCL is high) during step code 4 completes the step with result code 1 instead of 3.
- R8: Step code 5 pulls SDA low and step code 6 leaves it released, each applied while SCL is low. SDA is released after the next SCL falling edge, and the step completes with result code 4. SDA is never driven while no step is busy.
- R9: Step code 7 samples SDA on the next SCL rising edge and completes with result code 5 if SDA was low (ACK) or 6 if it was high (NAK).
- R10: Step codes 0 and 2 complete in the launch cycle with result code 7, never become busy, and do not touch SDA.
- R11: Status register: bit 0 is the done flag and bits 3:1 the result code. `irq` follows the done flag. Writing 1 to bit 0 clears the flag, and writing 0 has no effect.
- R12: The go bit reads 1 from the cycle after a launch until the step completes, then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_en | input | 1 | Unit is configured as target; enables launches |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 transmit byte, 2 status |
| wr_data | input | BYTE_W | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 received byte, 2 status |
| rd_data | output | BYTE_W | Read data (combinational) |
| irq | output | 1 | Step-done interrupt |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_drive | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
The SDA-change property checks the raw `scl_i` pin, not the synchronised copy. It therefore assumes that SCL holds each level for many more clock cycles than the synchroniser depth, and that steps are launched well inside an SCL-low phase. The bench's bus controller holds each SCL phase for 20 clocks and writes every trigger right after a falling edge. The launch properties also assume that software does not toggle `slave_en` while a step is busy, and the stimulus only changes it while the block is idle.

// File: rtl/i2c_step_target.sv
module i2c_step_target #(
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  localparam logic [2:0] M_START = 3'd1, M_TX = 3'd3, M_RX = 3'd4,
                         M_ACK = 3'd5, M_NAK = 3'd6, M_GETACK = 3'd7;
  localparam logic [2:0] C_START = 3'd0, C_STOP = 3'd1, C_TXD = 3'd2, C_RXD = 3'd3,
                         C_ACKOUT = 3'd4, C_ACKIN = 3'd5, C_NAKIN = 3'd6, C_RSV = 3'd7;

  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;
  logic [2:0] mode;
  logic busy, loaded, done;
  logic [2:0] code;
  logic [CNT_W-1:0] bitcnt;
  logic [BYTE_W-1:0] tx_byte, rx_byte, shreg;
  logic fin;
  logic [2:0] fin_code;

  wire scl_s = scl_q[SYNC_STAGES-1];
  wire sda_s = sda_q[SYNC_STAGES-1];
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  wire last = (bitcnt == LAST_BIT);

  wire ctl_wr = wr_en && (wr_addr == 2'd0);
  wire launch = ctl_wr && wr_data[4] && slave_en && !busy;
  wire rsv_sel = (wr_data[2:0] == 3'd0) || (wr_data[2:0] == 3'd2);

  assign irq = done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_comb begin
    fin = 1'b0;
    fin_code = C_RSV;
    if (launch && rsv_sel) begin
      fin = 1'b1;
    end else if (busy) begin
      case (mode)
        M_START:  if (start_c) begin fin = 1'b1; fin_code = C_START; end
        M_TX:     if (loaded && scl_fall && last) begin fin = 1'b1; fin_code = C_TXD; end
        M_RX: begin
          if (stop_c) begin
            fin = 1'b1; fin_code = C_STOP;
          end else if (scl_rise && last) begin
            fin = 1'b1; fin_code = C_RXD;
          end
        end
        M_ACK, M_NAK: if (loaded && scl_fall) begin fin = 1'b1; fin_code = C_ACKOUT; end
        M_GETACK: if (scl_rise) begin fin = 1'b1; fin_code = sda_s ? C_NAKIN : C_ACKIN; end
        default:  fin = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      tx_byte <= '0;
    end else if (wr_en) begin
      if (wr_addr == 2'd0 && !busy) mode <= wr_data[2:0];
      if (wr_addr == 2'd1) tx_byte <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      code <= '0;
    end else if (fin) begin
      done <= 1'b1;
      code <= fin_code;
    end else if (wr_en && wr_addr == 2'd2 && wr_data[0]) begin
      done <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      loaded <= 1'b0;
      bitcnt <= '0;
      shreg <= '0;
      rx_byte <= '0;
      sda_drive <= 1'b0;
    end else if (launch) begin
      busy <= !rsv_sel;
      loaded <= 1'b0;
      bitcnt <= '0;
      shreg <= tx_byte;
    end else if (busy) begin
      if (fin) begin
        busy <= 1'b0;
        sda_drive <= 1'b0;
        if (mode == M_RX && !stop_c) rx_byte <= {shreg[BYTE_W-2:0], sda_s};
      end else begin
        case (mode)
          M_TX: begin
            if (!loaded) begin
              if (!scl_s) begin
                sda_drive <= ~shreg[BYTE_W-1];
                loaded <= 1'b1;
              end
            end else if (scl_fall) begin
              bitcnt <= bitcnt + 1'b1;
              shreg <= {shreg[BYTE_W-2:0], 1'b0};
              sda_drive <= ~shreg[BYTE_W-2];
            end
          end
          M_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end
          end
          M_ACK, M_NAK: begin
            if (!loaded && !scl_s) begin
              sda_drive <= (mode == M_ACK);
              loaded <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      2'd0: begin
        rd_data[4] = busy;
        rd_data[2:0] = mode;
      end
      2'd1: rd_data = rx_byte;
      2'd2: begin
        rd_data[3:1] = code;
        rd_data[0] = done;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/i2c_step_target_chk.sv
module i2c_step_target_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slave_en,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic [1:0]        rd_addr,
  input logic [BYTE_W-1:0] rd_data,
  input logic              scl_i,
  input logic              sda_drive,
  input logic              busy,
  input logic              done
);
  wire go_wr = wr_en && (wr_addr == 2'd0) && wr_data[4];

  // R5 R8
  sda_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_drive != $past(sda_drive)) |-> !scl_i);

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_drive);

  // R12
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R3
  gated_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_en && !busy && go_wr) |=> !busy);

  // R10
  rsv_instant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_en && !busy && go_wr && (wr_data[2:0] == 3'd0 || wr_data[2:0] == 3'd2))
    |=> (done && !busy));

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(wr_en && wr_addr == 2'd2 && wr_data[0])) |=> done);

  // R2
  ctl_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd0) |-> (rd_data[7:5] == 3'd0 && rd_data[3] == 1'b0));
endmodule

bind i2c_step_target i2c_step_target_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
  .scl_i(scl_i), .sda_drive(sda_drive), .busy(busy), .done(done)
);

// File: tb/i2c_step_target_tb_top.sv
module i2c_step_target_tb_top;
  localparam int HALF = 20;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_en = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic irq, sda_drive;
  logic scl = 1'b1, sda_m = 1'b1;
  wire sda_line = sda_m & ~sda_drive;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  i2c_step_target dut_i (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .scl_i(scl), .sda_i(sda_line), .sda_drive(sda_drive)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic mbit(input logic v, output logic s);
    sda_m = v;
    wt(HALF);
    scl = 1'b1;
    wt(HALF / 2);
    s = sda_line;
    wt(HALF / 2);
    scl = 1'b0;
    wt(HALF);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(HALF);
    scl = 1'b1; wt(HALF);
    sda_m = 1'b0; wt(HALF);
    scl = 1'b0; wt(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(HALF);
    scl = 1'b1; wt(HALF);
    sda_m = 1'b1; wt(HALF);
  endtask

  task automatic expect_done(input string req, input logic [2:0] c);
    logic [7:0] d;
    wt(5);
    rd(2'd2, d);
    chk(req, d, {4'd0, c, 1'b1});
    chk({req, " irq"}, irq, 1'b1);
    wr(2'd2, 8'h01);
    rd(2'd2, d);
    chk("R11 clear", d[0], 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] d, b, got;
    logic s;
    wt(5);
    rst_n = 1'b1;
    wt(2);
    // R1
    rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
    rd(2'd2, d); chk("R1 status", d, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 sda", sda_drive, 1'b0);

    // R3
    slave_en = 1'b0;
    wr(2'd0, 8'h11);
    rd(2'd0, d); chk("R3 not busy", d, 8'h01);
    bus_start();
    rd(2'd2, d); chk("R3 no done", d[0], 1'b0);
    slave_en = 1'b1;

    // R2 go bit zero
    wr(2'd0, 8'h01);
    rd(2'd0, d); chk("R2 go zero", d, 8'h01);

    // R4 and R12
    wr(2'd0, 8'h11);
    rd(2'd0, d); chk("R12 busy", d, 8'h11);
    bus_start();
    expect_done("R4", 3'd0);
    rd(2'd0, d); chk("R12 idle", d, 8'h01);

    // R6 and R8 sweep
    for (int k = 0; k < 18; k++) begin
      b = 8'(k * 15);
      wr(2'd0, 8'h14);
      for (int i = 7; i >= 0; i--) mbit(b[i], s);
      expect_done("R6", 3'd3);
      rd(2'd1, d); chk("R6 data", d, b);
      wr(2'd0, k[0] ? 8'h16 : 8'h15);
      if (k == 0) begin
        wt(5);
        chk("R8 driving", sda_drive, 1'b1);
      end
      mbit(1'b1, s);
      chk("R8 level", s, k[0]);
      wt(5);
      chk("R8 release", sda_drive, 1'b0);
      expect_done("R8", 3'd4);
    end

    // R7
    wr(2'd0, 8'h14);
    bus_stop();
    expect_done("R7", 3'd1);
    wr(2'd0, 8'h11);
    bus_start();
    expect_done("R4 again", 3'd0);

    // R5 and R9 sweep
    for (int k = 0; k < 16; k++) begin
      b = 8'hA5 ^ 8'(k * 37);
      wr(2'd1, b);
      wr(2'd0, 8'h13);
      for (int i = 7; i >= 0; i--) begin
        mbit(1'b1, s);
        got[i] = s;
      end
      chk("R5 byte", got, b);
      wt(5);
      chk("R5 release", sda_drive, 1'b0);
      expect_done("R5", 3'd2);
      wr(2'd0, 8'h17);
      mbit(k[0], s);
      expect_done("R9", k[0] ? 3'd6 : 3'd5);
    end

    // R10
    wr(2'd0, 8'h10);
    rd(2'd0, d); chk("R10 mode0 idle", d, 8'h00);
    rd(2'd2, d); chk("R10 mode0", d, 8'h0F);
    chk("R10 sda", sda_drive, 1'b0);
    // R11 write zero keeps flag
    wr(2'd2, 8'h00);
    rd(2'd2, d); chk("R11 keep", d[0], 1'b1);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h12);
    rd(2'd0, d); chk("R10 mode2 idle", d, 8'h02);
    rd(2'd2, d); chk("R10 mode2", d, 8'h0F);
    wr(2'd2, 8'h01);

    // R2 writes while busy ignored
    wr(2'd0, 8'h14);
    wr(2'd0, 8'h11);
    rd(2'd0, d); chk("R2 busy write", d, 8'h14);
    bus_stop();
    expect_done("R7 end", 3'd1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule